// File: doc/BRIEF.md
# Trail Trace Identifier Transmitter

This block keeps a 16-byte trail access point identifier in a small bank of byte-wide registers that the host can write and read back. The transmit framer uses it as the source of the trail trace overhead byte. Each outbound frame carries one byte of the identifier. Over sixteen frames the whole identifier goes out once, and then the cycle starts again. The far end compares the received identifier with the one it expects, and so confirms that it is still connected to the intended transmitter.

The framer pulses `frame_start` once per outbound frame. On that clock edge the block captures the register chosen by its internal superframe position onto `tr_byte`, and then moves the position on by one. `tr_byte` holds that value for the whole frame. A one-cycle `sf_first` pulse marks the frame whose byte comes from register 0, which is the first frame of a superframe. The block sends register contents exactly as the host wrote them. By convention, software puts a 1 in bit 7 of register 0 only, which marks the superframe start for the far end.

Top module: `trail_trace_tx`

## Requirements
- R1: While `rst_n` is low, and after it is released, `tr_byte` reads 0x00 and `sf_first` reads 0. Reading register 0 returns 0x80 and reading registers 1 to 15 returns 0x00.
- R2: When `host_we` is high at a rising clock edge, `host_wdata` is stored in the register selected by `host_addr` (0 to 15). `host_rdata` always shows, without a clock, the contents of the register at `host_addr`.
- R3: At the rising edge where `frame_start` is high, `tr_byte` takes the contents of the register at the current superframe position. The new value is visible after that edge.
- R4: The superframe position is 0 after reset and advances by one on each `frame_start`. The first frame after reset therefore carries register 0, and the n-th frame carries register n-1.
- R5: After the frame that carries register 15, the next frame carries register 0.
- R6: `sf_first` is high for exactly the one cycle after a `frame_start` edge that loaded register 0. After every other `frame_start` edge it is 0.
- R7: A host write at the same edge as `frame_start`, to the register being loaded, does not change that frame's `tr_byte`: the old contents go out. The new value appears the next time that register comes round.
- R8: Bit 7 is sent exactly as written. Register 0 written as 0x05 goes out as 0x05, and any other register written as 0xFF goes out as 0xFF.
- R9: Without `frame_start`, `tr_byte` does not change, even when host writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write enable |
| host_addr | input | 4 | Host register index, 0 to 15 |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Contents of the register at `host_addr` |
| frame_start | input | 1 | One-cycle strobe from the framer at the start of each outbound frame |
| tr_byte | output | 8 | Trail trace byte for the current frame |
| sf_first | output | 1 | One-cycle pulse: the current frame is the first of a superframe |

## Verification
Some properties are checked by assertions on every cycle:
- `tr_byte` stays put between strobes.
- `sf_first` is always a lone pulse caused by a strobe, and it follows exactly every sixteenth strobe counted from reset.
- When the read port points at the register being loaded and no write is happening, the byte captured at a strobe equals what the read port showed.

Only the bench scenarios can show the rest:
- the full identifier sent in order and wrapping round;
- the write that collides with the capture of its own register;
- a cleared marker bit and a set bit 7 going out unchanged;
- the return to default contents after a reset in the middle of a run.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
   localparam int TTX_DEPTH   = 16;
   localparam int TTX_WIDTH   = 8;
   localparam logic [7:0] TTX_MARK_RST = 8'h80;
endpackage

// File: rtl/ttx_regfile.sv
module ttx_regfile #(
   parameter int           DEPTH   = 16,
   parameter int           WIDTH   = 8,
   parameter logic [WIDTH-1:0] FIRST_RST = '0,
   localparam int          AW      = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_idx,
   input  logic [WIDTH-1:0] wr_val,
   input  logic [AW-1:0]    hrd_idx,
   output logic [WIDTH-1:0] hrd_val,
   input  logic [AW-1:0]    seq_idx,
   output logic [WIDTH-1:0] seq_val
);
   logic [WIDTH-1:0] slot [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      localparam logic [WIDTH-1:0] RST_VAL = (gi == 0) ? FIRST_RST : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[gi] <= RST_VAL;
         else if (wr_en && (wr_idx == AW'(gi)))
            slot[gi] <= wr_val;
      end
   end

   assign hrd_val = slot[hrd_idx];
   assign seq_val = slot[seq_idx];
endmodule

// File: rtl/ttx_seq.sv
module ttx_seq #(
   parameter int  DEPTH = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [AW-1:0] pos,
   output logic          at_head
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos <= '0;
      else if (step)
         pos <= (pos == LAST) ? '0 : pos + AW'(1);
   end

   assign at_head = (pos == '0);
endmodule

// File: rtl/ttx_out.sv
module ttx_out #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   input  logic             head,
   output logic [WIDTH-1:0] dout,
   output logic             head_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout       <= '0;
         head_pulse <= 1'b0;
      end else begin
         head_pulse <= load && head;
         if (load)
            dout <= din;
      end
   end
endmodule

// File: rtl/trail_trace_tx.sv
module trail_trace_tx
   import ttx_pkg::*;
#(
   parameter int               DEPTH     = TTX_DEPTH,
   parameter int               WIDTH     = TTX_WIDTH,
   parameter logic [WIDTH-1:0] FIRST_RST = WIDTH'(TTX_MARK_RST),
   localparam int              AW        = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [AW-1:0]    host_addr,
   input  logic [WIDTH-1:0] host_wdata,
   output logic [WIDTH-1:0] host_rdata,
   input  logic             frame_start,
   output logic [WIDTH-1:0] tr_byte,
   output logic             sf_first
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("trail_trace_tx: DEPTH must be at least 2");
   end
   if ((1 << AW) != DEPTH) begin : g_bad_pow2
      $error("trail_trace_tx: DEPTH must be a power of two");
   end
   if (WIDTH < 2) begin : g_bad_width
      $error("trail_trace_tx: WIDTH must be at least 2");
   end

   logic [AW-1:0]    pos;
   logic             at_head;
   logic [WIDTH-1:0] sel_val;

   ttx_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH), .FIRST_RST(FIRST_RST)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (host_we),
      .wr_idx  (host_addr),
      .wr_val  (host_wdata),
      .hrd_idx (host_addr),
      .hrd_val (host_rdata),
      .seq_idx (pos),
      .seq_val (sel_val)
   );

   ttx_seq #(.DEPTH(DEPTH)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (frame_start),
      .pos     (pos),
      .at_head (at_head)
   );

   ttx_out #(.WIDTH(WIDTH)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (frame_start),
      .din        (sel_val),
      .head       (at_head),
      .dout       (tr_byte),
      .head_pulse (sf_first)
   );
endmodule

// File: rtl/trail_trace_tx_chk.sv
module trail_trace_tx_chk #(
   parameter int  DEPTH = 16,
   parameter int  WIDTH = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_we,
   input logic [AW-1:0]    host_addr,
   input logic [WIDTH-1:0] host_rdata,
   input logic             frame_start,
   input logic [WIDTH-1:0] tr_byte,
   input logic             sf_first
);
   logic [AW-1:0] strobes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         strobes <= '0;
      else if (frame_start)
         strobes <= strobes + AW'(1);
   end

   p_reset_r1: assert property (@(posedge clk) !rst_n |=> (tr_byte == '0 && !sf_first));

   p_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !host_we && host_addr == strobes) |=> tr_byte == $past(host_rdata));

   p_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && strobes == '0) |=> sf_first);

   p_nohead_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && strobes != '0) |=> !sf_first);

   p_lone_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sf_first |=> !sf_first);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(tr_byte) && !sf_first));
endmodule

bind trail_trace_tx trail_trace_tx_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_we     (host_we),
   .host_addr   (host_addr),
   .host_rdata  (host_rdata),
   .frame_start (frame_start),
   .tr_byte     (tr_byte),
   .sf_first    (sf_first)
);

// File: tb/tb_trail_trace_tx.sv
module tb_trail_trace_tx;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] ID_TAB [16] = '{
      8'hC5, 8'h4E, 8'h4F, 8'h44, 8'h45, 8'h2D, 8'h41, 8'h31,
      8'h2F, 8'h50, 8'h4F, 8'h52, 8'h54, 8'h33, 8'h0D, 8'h0A};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic [3:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       frame_start = 1'b0;
   logic [7:0] tr_byte;
   logic       sf_first;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] shadow [16];
   int cur = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trail_trace_tx dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .frame_start(frame_start), .tr_byte(tr_byte), .sf_first(sf_first));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic host_write(input int a, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = 4'(a); host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
      shadow[a] = d;
   endtask

   task automatic host_read_chk(input string req, input int a, input logic [7:0] exp);
      @(negedge clk);
      host_addr = 4'(a);
      #1;
      chk(req, host_rdata, exp);
   endtask

   // One frame strobe, optionally with a colliding host write; checks the captured byte.
   task automatic frame(input string req, input bit wr, input int a, input logic [7:0] d);
      logic [7:0] exp_b;
      logic       exp_f;
      exp_b = shadow[cur];
      exp_f = (cur == 0);
      @(negedge clk);
      frame_start = 1'b1;
      if (wr) begin host_we = 1'b1; host_addr = 4'(a); host_wdata = d; end
      @(negedge clk);
      frame_start = 1'b0; host_we = 1'b0;
      if (wr) shadow[a] = d;
      cur = (cur + 1) % 16;
      chk(req, tr_byte, exp_b);
      chk({req, " sf_first"}, 8'(sf_first), 8'(exp_f));
   endtask

   task automatic defaults();
      for (int i = 0; i < 16; i++) shadow[i] = (i == 0) ? 8'h80 : 8'h00;
      cur = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      defaults();
      repeat (3) @(negedge clk);
      chk("R1 tr_byte in reset", tr_byte, 8'h00);
      chk("R1 sf_first in reset", 8'(sf_first), 8'h00);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) host_read_chk("R1 default register", i, shadow[i]);

      // R2: load the identifier table and read it back
      for (int i = 0; i < 16; i++) host_write(i, ID_TAB[i]);
      for (int i = 0; i < 16; i++) host_read_chk("R2 readback", i, ID_TAB[i]);

      // R3 R4 R5 R6: walk 20 frames through the table, crossing the wrap
      for (int i = 0; i < 20; i++) begin
         chk("R4 table order", shadow[cur], ID_TAB[i % 16]);
         frame("R3 R5 frame byte", 1'b0, 0, 8'h00);
      end

      // R9: idle cycles and an unrelated write leave tr_byte alone
      repeat (4) @(negedge clk);
      chk("R9 hold", tr_byte, ID_TAB[3]);
      host_write(3, 8'h77);
      repeat (2) @(negedge clk);
      chk("R9 hold after write", tr_byte, ID_TAB[3]);
      chk("R9 no sf_first", 8'(sf_first), 8'h00);

      // R7: write to the register being captured at the same edge
      chk("R7 position", 8'(cur), 8'd4);
      frame("R7 colliding write keeps old byte", 1'b1, 4, 8'h5A);
      chk("R7 old value sent", tr_byte, ID_TAB[4]);
      for (int i = 0; i < 15; i++) frame("R7 cycle round", 1'b0, 0, 8'h00);
      frame("R7 new value next superframe", 1'b0, 0, 8'h00);
      chk("R7 new value sent", tr_byte, 8'h5A);

      // R8: marker bit is not forced
      host_write(0, 8'h05);
      host_write(7, 8'hFF);
      while (cur != 0) frame("R8 advance", 1'b0, 0, 8'h00);
      frame("R8 register 0 unmarked", 1'b0, 0, 8'h00);
      chk("R8 cleared marker sent", tr_byte, 8'h05);
      chk("R6 head pulse", 8'(sf_first), 8'h01);
      while (cur != 7) frame("R8 advance", 1'b0, 0, 8'h00);
      frame("R8 register 7 high bit", 1'b0, 0, 8'h00);
      chk("R8 set bit 7 sent", tr_byte, 8'hFF);

      // R1 R4: reset mid-run restores defaults and position 0
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 tr_byte after reset", tr_byte, 8'h00);
      rst_n = 1'b1;
      defaults();
      host_read_chk("R1 reg0 after reset", 0, 8'h80);
      host_read_chk("R1 reg7 after reset", 7, 8'h00);
      frame("R4 first frame after reset", 1'b0, 0, 8'h00);
      chk("R4 first byte is register 0", tr_byte, 8'h80);
      frame("R4 second frame", 1'b0, 0, 8'h00);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule